// File: doc/BRIEF.md
# Negate-and-add arithmetic unit

This block is a small combinational arithmetic unit. It takes two 4-bit two's-complement operands and a 2-bit operation code. It returns a 4-bit result together with a signed-overflow flag. The operations are: subtract in either operand order, add, and negate the first operand.

Internally there are two adders and two negate stages. Each negate stage inverts every bit and adds one. One adder forms `opb + (-opa)`. The second negate stage turns that difference into `opa - opb`. The other adder forms `opa + opb`. A 4-bit-wide four-way multiplexer then picks the answer named by the operation code. The result wraps modulo 16, and the carry out of the top bit is never kept.

There is no clock and no state. The outputs follow the inputs directly, so the block can sit anywhere in a datapath between registers owned by its neighbours.

Top module: `nas_unit`

## Requirements
- R1: With `op_sel` = 0, `result` equals `opb - opa` modulo 16.
- R2: With `op_sel` = 1, `result` equals `opa - opb` modulo 16.
- R3: With `op_sel` = 2, `result` equals `opa + opb` modulo 16.
- R4: With `op_sel` = 3, `result` equals the two's-complement negation of `opa` (invert all bits, add one), modulo 16.
- R5: Any carry beyond bit 3 is discarded. For example, with `op_sel` = 2, operands 15 and 1 give `result` = 0.
- R6: With `op_sel` = 2, `ovf` is 1 exactly when both operands have the same sign bit (bit 3) and `result` bit 3 differs from it.
- R7: For a subtraction X - Y (`op_sel` = 0: X = `opb`, Y = `opa`; `op_sel` = 1: X = `opa`, Y = `opb`), `ovf` is 1 exactly when X and Y differ in bit 3 and `result` bit 3 differs from bit 3 of X.
- R8: With `op_sel` = 3, `ovf` is 1 exactly when `opa` = 4'b1000, the most negative value.
- R9: The block is purely combinational. A change on any input shows on `result` and `ovf` without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | 4 | First operand, two's complement |
| opb | input | 4 | Second operand, two's complement |
| op_sel | input | 2 | Operation code: 0 = opb-opa, 1 = opa-opb, 2 = opa+opb, 3 = -opa |
| result | output | 4 | Result, modulo 16 |
| ovf | output | 1 | Signed overflow of the selected operation |

## Verification
The bound checker re-evaluates on every input change. It checks that the selected result matches the arithmetic identity for its operation code. It also checks that the overflow flag agrees with the sign rule for that code, including the single overflowing negation input.

Only the bench's scenarios show the remaining behaviour. The bench runs an exhaustive sweep of all 1024 combinations of operands and codes and compares each against wide-integer arithmetic. That sweep exposes wraparound at the carry boundary. A separate step changes the inputs between clock edges and observes the outputs, which shows that they settle from the inputs alone.

// File: rtl/nas_pkg.sv
package nas_pkg;

    localparam int unsigned OPW = 2;

    typedef enum logic [OPW-1:0] {
        OP_SUB_BA = 2'd0,
        OP_SUB_AB = 2'd1,
        OP_ADD    = 2'd2,
        OP_NEG_A  = 2'd3
    } nas_op_e;

endpackage

// File: rtl/nas_negate.sv
// Two's-complement negation: invert every bit, then increment through a
// half-adder chain. The carry out of the top bit is not formed.
module nas_negate #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] inv;
    logic [W-1:0] cy;   // carry into bit i

    assign inv   = ~din;
    assign cy[0] = 1'b1;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign dout[i] = inv[i] ^ cy[i];
        if (i < W - 1) begin : g_cy
            assign cy[i+1] = inv[i] & cy[i];
        end
    end
endmodule

// File: rtl/nas_ripple_add.sv
// Modulo 2^W ripple adder built from full-adder cells; carry out dropped.
module nas_ripple_add #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic [W-1:0] sum
);
    logic [W-1:0] cy;   // carry into bit i

    assign cy[0] = 1'b0;

    for (genvar i = 0; i < W; i++) begin : g_fa
        assign sum[i] = x[i] ^ y[i] ^ cy[i];
        if (i < W - 1) begin : g_cy
            assign cy[i+1] = (x[i] & y[i]) | (cy[i] & (x[i] ^ y[i]));
        end
    end
endmodule

// File: rtl/nas_mux4.sv
// W-bit four-way selector driven by the operation code.
module nas_mux4
    import nas_pkg::*;
#(
    parameter int unsigned W = 4
) (
    input  nas_op_e      sel,
    input  logic [W-1:0] in_sub_ba,
    input  logic [W-1:0] in_sub_ab,
    input  logic [W-1:0] in_add,
    input  logic [W-1:0] in_neg_a,
    output logic [W-1:0] dout
);
    always_comb begin
        unique case (sel)
            OP_SUB_BA: dout = in_sub_ba;
            OP_SUB_AB: dout = in_sub_ab;
            OP_ADD:    dout = in_add;
            OP_NEG_A:  dout = in_neg_a;
            default:   dout = '0;
        endcase
    end
endmodule

// File: rtl/nas_unit.sv
// Negate-and-add arithmetic unit, top level.
module nas_unit
    import nas_pkg::*;
#(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0]   opa,
    input  logic [W-1:0]   opb,
    input  logic [OPW-1:0] op_sel,
    output logic [W-1:0]   result,
    output logic           ovf
);
    localparam int unsigned MSB = W - 1;

    nas_op_e      op;
    logic [W-1:0] neg_a;     // -opa
    logic [W-1:0] diff_ba;   // opb - opa
    logic [W-1:0] diff_ab;   // opa - opb = -(opb - opa)
    logic [W-1:0] sum_ab;    // opa + opb
    logic [W-1:0] min_val;   // most negative value

    assign op      = nas_op_e'(op_sel);
    assign min_val = {1'b1, {(W-1){1'b0}}};

    nas_negate #(.W(W)) u_neg_a (
        .din  (opa),
        .dout (neg_a)
    );

    nas_ripple_add #(.W(W)) u_add_diff (
        .x   (opb),
        .y   (neg_a),
        .sum (diff_ba)
    );

    nas_negate #(.W(W)) u_neg_diff (
        .din  (diff_ba),
        .dout (diff_ab)
    );

    nas_ripple_add #(.W(W)) u_add_sum (
        .x   (opa),
        .y   (opb),
        .sum (sum_ab)
    );

    nas_mux4 #(.W(W)) u_sel (
        .sel       (op),
        .in_sub_ba (diff_ba),
        .in_sub_ab (diff_ab),
        .in_add    (sum_ab),
        .in_neg_a  (neg_a),
        .dout      (result)
    );

    // Signed overflow, decided from operand signs and the chosen result.
    always_comb begin
        unique case (op)
            OP_SUB_BA: ovf = (opa[MSB] != opb[MSB]) && (diff_ba[MSB] != opb[MSB]);
            OP_SUB_AB: ovf = (opa[MSB] != opb[MSB]) && (diff_ab[MSB] != opa[MSB]);
            OP_ADD:    ovf = (opa[MSB] == opb[MSB]) && (sum_ab[MSB] != opa[MSB]);
            OP_NEG_A:  ovf = (opa == min_val);
            default:   ovf = 1'b0;
        endcase
    end
endmodule

// File: rtl/nas_unit_chk.sv
// Checker bound to nas_unit; re-evaluated on every input change.
module nas_unit_chk #(
    parameter int unsigned W = 4
) (
    input logic [W-1:0] opa,
    input logic [W-1:0] opb,
    input logic [1:0]   op_sel,
    input logic [W-1:0] result,
    input logic         ovf
);
    localparam int unsigned MSB = W - 1;

    logic [W-1:0] e_sub_ba, e_sub_ab, e_add, e_neg;

    always_comb begin
        e_sub_ba = W'(opb - opa);
        e_sub_ab = W'(opa - opb);
        e_add    = W'(opa + opb);
        e_neg    = W'(~opa + 1'b1);
        if (!$isunknown({opa, opb, op_sel, result, ovf})) begin
            if (op_sel == 2'd0) begin
                assert_sub_ba_R1: assert (result == e_sub_ba);
                assert_ovf_sub_ba_R7: assert (ovf == ((opa[MSB] != opb[MSB]) && (result[MSB] != opb[MSB])));
            end
            if (op_sel == 2'd1) begin
                assert_sub_ab_R2: assert (result == e_sub_ab);
                assert_ovf_sub_ab_R7: assert (ovf == ((opa[MSB] != opb[MSB]) && (result[MSB] != opa[MSB])));
            end
            if (op_sel == 2'd2) begin
                assert_add_R3: assert (result == e_add);
                assert_wrap_R5: assert (({1'b0, opa} + {1'b0, opb}) < (1 << W) || result == W'(({1'b0, opa} + {1'b0, opb}) - (1 << W)));
                assert_ovf_add_R6: assert (ovf == ((opa[MSB] == opb[MSB]) && (result[MSB] != opa[MSB])));
            end
            if (op_sel == 2'd3) begin
                assert_neg_R4: assert (result == e_neg);
                assert_ovf_neg_R8: assert (ovf == (opa == {1'b1, {(W-1){1'b0}}}));
            end
        end
    end
endmodule

bind nas_unit nas_unit_chk #(.W(W)) u_chk (
    .opa    (opa),
    .opb    (opb),
    .op_sel (op_sel),
    .result (result),
    .ovf    (ovf)
);

// File: tb/nas_unit_test.sv
module nas_unit_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] opa = '0;
    logic [3:0] opb = '0;
    logic [1:0] op_sel = '0;
    logic [3:0] result;
    logic       ovf;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;   // 200 MHz

    nas_unit uut (
        .opa    (opa),
        .opb    (opb),
        .op_sel (op_sel),
        .result (result),
        .ovf    (ovf)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: a=%0d b=%0d op=%0d actual=%0d expected=%0d",
                     tag, opa, opb, op_sel, act, exp);
        end
    endtask

    function automatic int sval(input logic [3:0] v);
        return (v >= 8) ? int'(v) - 16 : int'(v);
    endfunction

    task automatic run_case(input int a, input int b, input int op);
        int sa, sb, ua, ub, tru, exp_d, exp_v;
        string rtag, vtag;
        @(negedge clk);
        opa = 4'(a); opb = 4'(b); op_sel = 2'(op);
        #1;
        sa = sval(4'(a)); sb = sval(4'(b)); ua = a; ub = b;
        case (op)
            0: begin tru = sb - sa; rtag = "R1"; vtag = "R7"; end
            1: begin tru = sa - sb; rtag = "R2"; vtag = "R7"; end
            2: begin tru = sa + sb; vtag = "R6";
                     rtag = (ua + ub > 15) ? "R5" : "R3"; end
            default: begin tru = -sa; rtag = "R4"; vtag = "R8"; end
        endcase
        exp_d = ((tru % 16) + 16) % 16;
        exp_v = (tru > 7 || tru < -8) ? 1 : 0;
        check(rtag, int'(result), exp_d);
        check(vtag, int'(ovf), exp_v);
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Initial state: zero inputs, op 0 -> result 0, no overflow (R1).
        @(negedge clk); #1;
        check("R1", int'(result), 0);
        check("R7", int'(ovf), 0);

        // R9: inputs change between edges; outputs follow with no edge.
        @(posedge clk); #0.5;
        opa = 4'd3; opb = 4'd9; op_sel = 2'd2;
        #0.5;
        check("R9", int'(result), 12);
        opa = 4'd8; op_sel = 2'd3;
        #0.5;
        check("R9", int'(result), 8);
        check("R9", int'(ovf), 1);

        // Named corner cases.
        run_case(15, 1, 2);   // R5 wrap to 0
        run_case(7, 1, 2);    // R6 positive overflow
        run_case(8, 8, 2);    // R6 negative overflow
        run_case(8, 0, 3);    // R8 -(-8)
        run_case(0, 8, 1);    // R7 0-(-8)
        run_case(8, 0, 0);    // R7 0-(-8)

        // Exhaustive sweep of all operand pairs and codes.
        for (int op = 0; op < 4; op++)
            for (int a = 0; a < 16; a++)
                for (int b = 0; b < 16; b++)
                    run_case(a, b, op);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule